// File: doc/BRIEF.md
# In-Band Transmit Flow Control with Resume-On-Any

This block sits between a serial receiver and its transmitter and carries out character-based (in-band) flow control. Every character the receiver delivers is compared over its full width against two programmable codes: a stop code and a start code. A stop code pauses the transmitter. A start code releases it. Whether a received character reaches the receive FIFO is decided on the same cycle the character arrives.

A resume-on-any mode bit widens the release rule. When the bit is set, any character that arrives while the transmitter is paused releases it, except the stop code itself. Even in this mode the control codes never enter the FIFO, so the data stream stays clean. When flow control is switched off, the block passes every character through to the FIFO and never pauses the transmitter.

The pause output is registered. A character already being shifted out is left to complete, because the transmitter samples the pause level only between characters.

Top module: `sfc_flow_ctrl`

## Requirements
- R1: After reset `tx_pause` is 0.
- R2: While `flow_en` is 0, `rx_push` equals `rx_valid` on the same cycle and `tx_pause` is 0.
- R3: With `flow_en` at 1, a strobe (`rx_valid`=1) whose `rx_data` equals `stop_code` makes `tx_pause` 1 from the cycle after the strobe.
- R4: With `flow_en` at 1, a strobe carrying `start_code` (and not `stop_code`) makes `tx_pause` 0 from the cycle after, whatever the value of `any_resume`.
- R5: With `any_resume` at 0, a strobe carrying a character equal to neither code leaves `tx_pause` unchanged.
- R6: With `any_resume` at 1 and the transmitter paused, a strobe carrying any character other than `stop_code` makes `tx_pause` 0 from the next cycle.
- R7: With `flow_en` at 1, a strobe carrying `start_code` or `stop_code` gives `rx_push`=0 on that cycle, in either mode. Any other character gives `rx_push`=1.
- R8: The stop code has priority. It pauses the transmitter even when `any_resume` is 1. When both codes hold the same value, a matching strobe pauses.
- R9: Code matching is exact over all DATA_W bits. A character that differs from a code in a single bit is treated as ordinary data.
- R10: Without a strobe, `rx_push` is 0 and `tx_pause` keeps its value, except that it falls to 0 when `flow_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | DATA_W | The received character |
| flow_en | input | 1 | Enables in-band flow control |
| any_resume | input | 1 | Resume-on-any mode bit (held 0 by its register's reset) |
| start_code | input | DATA_W | Programmed resume code |
| stop_code | input | DATA_W | Programmed pause code |
| tx_pause | output | 1 | Transmitter must not start a new character |
| rx_push | output | 1 | Write the current character into the receive FIFO |

## Verification
The bench builds the block with the default DATA_W of 8, which is the character width in real use. At that width the single-bit-off characters of R9 cover all eight bit positions. Random character streams are biased toward the two codes and their one-bit neighbours, so that code matches and near misses occur in large numbers. The codes are reprogrammed from time to time, including to equal values, which makes the R8 tie reachable.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   typedef enum logic [1:0] {
      CK_DATA = 2'd0,
      CK_START = 2'd1,
      CK_STOP = 2'd2
   } char_kind_e;
endpackage

// File: rtl/sfc_code_match.sv
module sfc_code_match #(
   parameter int W = 8
) (
   input  logic [W-1:0] value,
   input  logic [W-1:0] code,
   output logic         hit
);
   logic [W-1:0] bit_eq;
   genvar i;
   for (i = 0; i < W; i++) begin : g_bit
      assign bit_eq[i] = ~(value[i] ^ code[i]);
   end
   assign hit = &bit_eq;
endmodule

// File: rtl/sfc_classify.sv
module sfc_classify
   import sfc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] rx_data,
   input  logic [DATA_W-1:0] start_code,
   input  logic [DATA_W-1:0] stop_code,
   output char_kind_e        kind
);
   logic hit_start, hit_stop;

   sfc_code_match #(.W(DATA_W)) u_start (
      .value(rx_data), .code(start_code), .hit(hit_start));
   sfc_code_match #(.W(DATA_W)) u_stop (
      .value(rx_data), .code(stop_code), .hit(hit_stop));

   always_comb begin
      if (hit_stop)       kind = CK_STOP;   // stop wins a tie
      else if (hit_start) kind = CK_START;
      else                kind = CK_DATA;
   end
endmodule

// File: rtl/sfc_pause_ctl.sv
module sfc_pause_ctl
   import sfc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flow_en,
   input  logic       any_resume,
   input  logic       rx_valid,
   input  char_kind_e kind,
   output logic       pause_q
);
   logic pause_d;

   always_comb begin
      pause_d = pause_q;
      if (!flow_en) begin
         pause_d = 1'b0;
      end else if (rx_valid) begin
         unique case (kind)
            CK_STOP:  pause_d = 1'b1;
            CK_START: pause_d = 1'b0;
            default:  if (any_resume) pause_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pause_q <= 1'b0;
      else        pause_q <= pause_d;
   end

   // R3
   stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_en && rx_valid && kind == CK_STOP |=> pause_q);
   // R4
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_en && rx_valid && kind == CK_START |=> !pause_q);
   // R6
   any_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_en && rx_valid && any_resume && kind != CK_STOP |=> !pause_q);
   // R5
   data_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_en && rx_valid && !any_resume && kind == CK_DATA |=> $stable(pause_q));
   // R10
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_en && !rx_valid |=> $stable(pause_q));
endmodule

// File: rtl/sfc_push_gate.sv
module sfc_push_gate
   import sfc_pkg::*;
(
   input  logic       rx_valid,
   input  logic       flow_en,
   input  char_kind_e kind,
   output logic       rx_push
);
   always_comb begin
      rx_push = rx_valid;
      if (flow_en && kind != CK_DATA) rx_push = 1'b0;
   end
endmodule

// File: rtl/sfc_flow_ctrl.sv
module sfc_flow_ctrl
   import sfc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              flow_en,
   input  logic              any_resume,
   input  logic [DATA_W-1:0] start_code,
   input  logic [DATA_W-1:0] stop_code,
   output logic              tx_pause,
   output logic              rx_push
);
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("sfc_flow_ctrl: DATA_W must be 5..9");
   end

   char_kind_e kind;
   logic       pause_q;

   sfc_classify #(.DATA_W(DATA_W)) u_classify (
      .rx_data(rx_data), .start_code(start_code), .stop_code(stop_code),
      .kind(kind));

   sfc_pause_ctl u_pause (
      .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .any_resume(any_resume),
      .rx_valid(rx_valid), .kind(kind), .pause_q(pause_q));

   sfc_push_gate u_push (
      .rx_valid(rx_valid), .flow_en(flow_en), .kind(kind), .rx_push(rx_push));

   assign tx_pause = pause_q & flow_en;

   // R2
   off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flow_en |-> !tx_pause && (rx_push == rx_valid));
   // R7
   codes_filtered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_en && rx_valid && (rx_data == start_code || rx_data == stop_code)
      |-> !rx_push);
   // R10
   push_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> rx_valid);
endmodule

// File: tb/sfc_flow_ctrl_bench.sv
`timescale 1ns/1ps
module sfc_flow_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       flow_en = 1'b0;
   logic       any_resume = 1'b0;
   logic [7:0] start_code = 8'h11;
   logic [7:0] stop_code = 8'h13;
   logic       tx_pause, rx_push;

   int n_cmp = 0;
   int n_bad = 0;
   logic model_pause = 1'b0;

   always #10 clk = ~clk;

   sfc_flow_ctrl #(.DATA_W(8)) u_sfc_flow_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .flow_en(flow_en), .any_resume(any_resume), .start_code(start_code),
      .stop_code(stop_code), .tx_pause(tx_pause), .rx_push(rx_push));

   function automatic logic exp_push(logic v, logic [7:0] d, logic fe,
                                     logic [7:0] sc, logic [7:0] pc);
      if (!v) return 1'b0;
      if (fe && (d == sc || d == pc)) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic next_pause(logic cur, logic v, logic [7:0] d,
                                       logic fe, logic xa,
                                       logic [7:0] sc, logic [7:0] pc);
      if (!fe) return 1'b0;
      if (!v) return cur;
      if (d == pc) return 1'b1;
      if (d == sc) return 1'b0;
      if (xa) return 1'b0;
      return cur;
   endfunction

   function automatic string tag_for(logic v, logic [7:0] d, logic fe, logic xa,
                                     logic [7:0] sc, logic [7:0] pc);
      if (!fe) return "R2";
      if (!v) return "R10";
      if (d == pc) return (xa || sc == pc) ? "R8" : "R3";
      if (d == sc) return (xa ? "R4" : "R7");
      if ($countones(d ^ sc) == 1 || $countones(d ^ pc) == 1) return "R9";
      return xa ? "R6" : "R5";
   endfunction

   task automatic check(string tag, string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // Called at a negative edge; applies one cycle of stimulus and checks it.
   task automatic cycle(logic v, logic [7:0] d, logic fe, logic xa);
      string tg;
      rx_valid = v; rx_data = d; flow_en = fe; any_resume = xa;
      tg = tag_for(v, d, fe, xa, start_code, stop_code);
      #3;
      check(tg, "rx_push", rx_push, exp_push(v, d, fe, start_code, stop_code));
      @(posedge clk);
      model_pause = next_pause(model_pause, v, d, fe, xa, start_code, stop_code);
      #2;
      check(tg, "tx_pause", tx_pause, model_pause & fe);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic fe, xa;
      int r;
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1", "tx_pause", tx_pause, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "tx_pause", tx_pause, 1'b0);

      // Directed corners
      cycle(1'b1, 8'h13, 1'b1, 1'b0);   // R3 stop pauses
      cycle(1'b1, 8'h41, 1'b1, 1'b0);   // R5 data holds pause
      cycle(1'b0, 8'h13, 1'b1, 1'b0);   // R10 no strobe
      cycle(1'b1, 8'h10, 1'b1, 1'b0);   // R9 one bit off start code
      cycle(1'b1, 8'h11, 1'b1, 1'b0);   // R4 start resumes
      cycle(1'b1, 8'h13, 1'b1, 1'b1);   // R8 stop wins in any-resume
      cycle(1'b1, 8'h55, 1'b1, 1'b1);   // R6 any char resumes
      cycle(1'b1, 8'h13, 1'b1, 1'b1);
      cycle(1'b1, 8'h11, 1'b1, 1'b1);   // R4/R7 start filtered, resumes
      cycle(1'b1, 8'h13, 1'b1, 1'b0);
      cycle(1'b1, 8'h13, 1'b0, 1'b0);   // R2 disabled: pushes, pause 0
      cycle(1'b1, 8'h11, 1'b0, 1'b1);   // R2
      stop_code = 8'h2A; start_code = 8'h2A;
      cycle(1'b1, 8'h2A, 1'b1, 1'b1);   // R8 equal codes pause
      cycle(1'b1, 8'h2B, 1'b1, 1'b0);   // R9 one bit off both codes

      // Random phase
      for (int k = 0; k < 4000; k++) begin
         if (k % 250 == 0) begin
            start_code = 8'($urandom);
            stop_code = ($urandom % 8 == 0) ? start_code : 8'($urandom);
         end
         r = $urandom % 100;
         if (r < 30)      d = start_code;
         else if (r < 50) d = stop_code;
         else if (r < 70) d = start_code ^ (8'h01 << ($urandom % 8));
         else if (r < 80) d = stop_code ^ (8'h01 << ($urandom % 8));
         else             d = 8'($urandom);
         fe = ($urandom % 10) != 0;
         xa = ((k / 60) % 2) == 1;
         cycle(($urandom % 4) != 0, d, fe, xa);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule